// File: doc/BRIEF.md
# Interrupt Controller Command Port

This block is the byte-wide programming port of an eight-line interrupt controller. Software reaches it through a one-bit address, separate write and read strobes and an 8-bit data bus. Writes at address 0 either start the initialization word sequence or carry an operational command. Writes at address 1 either feed the remaining initialization words or load the mask register. The block keeps the mask register, the vector base, the rotating priority base and the mode flags. It drives one-cycle clear strobes for in-service bits to the priority resolver that owns the in-service register.

The resolver supplies the current request and in-service registers. The port needs the in-service register to pick the line that a non-specific end-of-interrupt clears, and it returns either register on reads. The priority arbitration and the acknowledge cycle live outside this block.

Top module: `irqc_cmd_port`

## Requirements
- R1: After synchronous reset the mask, vector base and priority base read zero. Initialization is idle and all mode flags are clear. No clear strobe is active and reads at address 0 return the request register.
- R2: A write at address 0 with data bit 4 set starts initialization. It clears the mask, the priority base, the special-mask, rotate-on-auto-EOI, nested and auto-EOI flags, and the read select (back to request). It pulses `insvc_clr_all` for one cycle and raises `init_busy`. Data bit 1 is latched as single-unit mode and bit 0 as "fourth word wanted". Bit 3, the level-trigger request, is ignored.
- R3: The first address-1 write after the start word sets the vector base to the data with its three low bits forced to zero.
- R4: After the vector word, initialization expects a cascade word when not in single-unit mode. In single-unit mode it expects the fourth word if one was requested, and otherwise ends. After the cascade word it expects the fourth word if requested, and otherwise ends. Address-1 writes consumed by the sequence do not touch the mask.
- R5: In the fourth initialization word, data bit 4 sets the special nested flag and bit 1 sets the auto-EOI flag. The word ends initialization.
- R6: A write at address 0 with bit 4 clear and bit 3 set is a read-control word. Bit 0 selects what address-0 reads return (1 = in-service, 0 = request), and bit 5 loads the special-mask flag.
- R7: Other address-0 writes carry a command in data bits 7:5. Commands 0 and 4 load the rotate-on-auto-EOI flag from data bit 7. Command 2 changes nothing.
- R8: Command 1 clears the in-service line found first when scanning upward from the priority base, modulo 8. Command 5 does the same and also sets the priority base to that line plus one. When no in-service bit is set, neither command clears anything or moves the base.
- R9: Command 3 clears in-service line data[2:0]. Command 6 sets the priority base to data[2:0]+1 mod 8. Command 7 clears line data[2:0] and sets the base to data[2:0]+1 mod 8.
- R10: With initialization idle, an address-1 write loads the mask. A read returns, one edge after the strobe, the mask at address 1 or the selected register at address 0. It holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 1 | Register address |
| wr_en | input | 1 | Write strobe, one cycle per byte |
| rd_en | input | 1 | Read strobe, one cycle per byte |
| wdata | input | 8 | Write data |
| req_in | input | 8 | Request register from the resolver |
| insvc_in | input | 8 | In-service register from the resolver |
| rdata | output | 8 | Registered read data |
| mask_out | output | 8 | Interrupt mask register |
| vec_base | output | 8 | Vector base, low three bits zero |
| prio_base | output | 3 | Line that currently has the highest priority |
| insvc_clr | output | 8 | One-cycle per-line in-service clear strobe |
| insvc_clr_all | output | 1 | One-cycle clear of the whole in-service register |
| init_busy | output | 1 | Initialization sequence in progress |
| single_unit | output | 1 | Single (non-cascaded) mode flag |
| nested_special | output | 1 | Special nested mode flag |
| auto_eoi | output | 1 | Automatic end-of-interrupt flag |
| rot_on_aeoi | output | 1 | Rotate-on-auto-EOI flag |
| spec_mask | output | 1 | Special mask flag |

## Verification
Every write takes effect on the clock edge that samples its strobe. The mask, vector base, priority base, flags and `init_busy` are therefore new from that edge on. Both clear strobes are high only in the single cycle that follows that edge. Read data appears on the edge that samples `rd_en`. The bench drives one strobe per cycle away from the rising edge. The driver queues the expected values right after the sampling edge, and the monitor compares them on the very next falling edge, which is the only point where the one-cycle strobes can be seen.

// File: rtl/irqc_pkg.sv
`timescale 1ns/1ps
// Shared types of the interrupt controller command port.
// Assumes an 8-line controller with the command code in the top three data bits.
package irqc_pkg;

    // Initialization sequence position.
    typedef enum logic [1:0] {
        ST_READY = 2'd0,
        ST_BASE  = 2'd1,
        ST_CASC  = 2'd2,
        ST_EXTRA = 2'd3
    } init_st_t;

    // Operational command codes carried in data bits 7:5.
    typedef enum logic [2:0] {
        CMD_ROT_OFF  = 3'd0,
        CMD_NS_EOI   = 3'd1,
        CMD_NOP      = 3'd2,
        CMD_SP_EOI   = 3'd3,
        CMD_ROT_ON   = 3'd4,
        CMD_NS_ROT   = 3'd5,
        CMD_SET_PRIO = 3'd6,
        CMD_SP_ROT   = 3'd7
    } cmd_t;

endpackage

// File: rtl/irqc_init_seq.sv
`timescale 1ns/1ps
// Initialization word sequencer.
// Tracks the position in the start/vector/cascade/fourth word sequence and
// holds the vector base, single-unit and fourth-word mode flags.
// Assumes the caller decodes the start word and address-1 writes.
module irqc_init_seq #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_stb,
    input  logic              port1_stb,
    input  logic [DATA_W-1:0] wdata,
    output logic              busy,
    output logic              single_unit,
    output logic              nested_special,
    output logic              auto_eoi,
    output logic [DATA_W-1:0] vec_base
);
    import irqc_pkg::*;

    localparam int LINE_W = $clog2(DATA_W);
    localparam logic [DATA_W-1:0] VEC_MASK = ~DATA_W'((1 << LINE_W) - 1);

    init_st_t st;
    logic     want_fourth;

    // Advance the sequence and capture the fields each word carries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st             <= ST_READY;
            single_unit    <= 1'b0;
            want_fourth    <= 1'b0;
            nested_special <= 1'b0;
            auto_eoi       <= 1'b0;
            vec_base       <= '0;
        end else if (start_stb) begin
            st             <= ST_BASE;
            single_unit    <= wdata[1];
            want_fourth    <= wdata[0];
            nested_special <= 1'b0;
            auto_eoi       <= 1'b0;
        end else if (port1_stb) begin
            case (st)
                ST_BASE: begin
                    vec_base <= wdata & VEC_MASK;
                    if (!single_unit)
                        st <= ST_CASC;
                    else
                        st <= want_fourth ? ST_EXTRA : ST_READY;
                end
                ST_CASC: st <= want_fourth ? ST_EXTRA : ST_READY;
                ST_EXTRA: begin
                    nested_special <= wdata[4];
                    auto_eoi       <= wdata[1];
                    st             <= ST_READY;
                end
                default: st <= ST_READY;
            endcase
        end
    end

    // Sequence in progress whenever a word is still expected.
    always_comb busy = (st != ST_READY);

    // A start word always leaves the sequencer busy.
    p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_stb |=> busy);

    // A single-unit sequence without a fourth word ends on the vector word.
    p_single_short_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_BASE && port1_stb && !start_stb && single_unit && !want_fourth) |=> !busy);

    // The vector word never leaves low bits set.
    p_vec_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_BASE && port1_stb && !start_stb) |=>
            (vec_base[LINE_W-1:0] == '0 && vec_base[DATA_W-1:LINE_W] == $past(wdata[DATA_W-1:LINE_W])));

endmodule

// File: rtl/irqc_cmd_exec.sv
`timescale 1ns/1ps
// Operational command executor.
// Decodes read-control words and the eight command codes, keeps the
// priority base and the read-select, special-mask and rotate flags, and
// emits one-cycle in-service clear strobes. Assumes insvc_in is the
// resolver's current in-service register.
module irqc_cmd_exec #(
    parameter int DATA_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start_stb,
    input  logic                       rdctl_stb,
    input  logic                       cmd_stb,
    input  logic [DATA_W-1:0]          wdata,
    input  logic [DATA_W-1:0]          insvc_in,
    output logic [$clog2(DATA_W)-1:0]  prio_base,
    output logic [DATA_W-1:0]          insvc_clr,
    output logic                       rd_insvc_sel,
    output logic                       spec_mask,
    output logic                       rot_on_aeoi
);
    import irqc_pkg::*;

    localparam int LINE_W = $clog2(DATA_W);

    cmd_t              cmd;
    logic              hit_found;
    logic [LINE_W-1:0] hit_line;
    logic [LINE_W-1:0] scan_idx;
    logic [LINE_W-1:0] sel_line;
    logic [1:0]        unused_bits;

    // Command field and explicit line number from the data byte.
    always_comb begin
        cmd         = cmd_t'(wdata[DATA_W-1:DATA_W-3]);
        sel_line    = wdata[LINE_W-1:0];
        unused_bits = wdata[4:3];
    end

    // Find the set in-service line closest above the priority base.
    always_comb begin
        hit_found = 1'b0;
        hit_line  = '0;
        scan_idx  = '0;
        for (int i = DATA_W - 1; i >= 0; i--) begin
            scan_idx = prio_base + LINE_W'(i);
            if (insvc_in[scan_idx]) begin
                hit_found = 1'b1;
                hit_line  = scan_idx;
            end
        end
    end

    // Execute start, read-control and command words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prio_base    <= '0;
            insvc_clr    <= '0;
            rd_insvc_sel <= 1'b0;
            spec_mask    <= 1'b0;
            rot_on_aeoi  <= 1'b0;
        end else begin
            insvc_clr <= '0;
            if (start_stb) begin
                prio_base    <= '0;
                rd_insvc_sel <= 1'b0;
                spec_mask    <= 1'b0;
                rot_on_aeoi  <= 1'b0;
            end else if (rdctl_stb) begin
                rd_insvc_sel <= wdata[0];
                spec_mask    <= wdata[5];
            end else if (cmd_stb) begin
                case (cmd)
                    CMD_ROT_OFF, CMD_ROT_ON: rot_on_aeoi <= wdata[DATA_W-1];
                    CMD_NS_EOI: begin
                        if (hit_found)
                            insvc_clr <= DATA_W'(1) << hit_line;
                    end
                    CMD_NS_ROT: begin
                        if (hit_found) begin
                            insvc_clr <= DATA_W'(1) << hit_line;
                            prio_base <= hit_line + LINE_W'(1);
                        end
                    end
                    CMD_SP_EOI: insvc_clr <= DATA_W'(1) << sel_line;
                    CMD_SET_PRIO: prio_base <= sel_line + LINE_W'(1);
                    CMD_SP_ROT: begin
                        insvc_clr <= DATA_W'(1) << sel_line;
                        prio_base <= sel_line + LINE_W'(1);
                    end
                    default: ;
                endcase
            end
        end
    end

    // At most one line is cleared per command.
    p_clr_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(insvc_clr));

    // A non-specific clear only ever hits a line that was in service.
    p_clr_was_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stb && !start_stb && !rdctl_stb && (cmd == CMD_NS_EOI || cmd == CMD_NS_ROT))
            |=> ((insvc_clr & ~$past(insvc_in)) == '0));

    // Non-specific commands with nothing in service leave everything alone.
    p_empty_eoi_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stb && !start_stb && !rdctl_stb && insvc_in == '0 &&
         (cmd == CMD_NS_EOI || cmd == CMD_NS_ROT)) |=> (insvc_clr == '0 && $stable(prio_base)));

endmodule

// File: rtl/irqc_rd_port.sv
`timescale 1ns/1ps
// Registered read-back of the port.
// Returns the mask at address 1, and the in-service or request register at
// address 0 as chosen by the read select. Holds the value between reads.
module irqc_rd_port #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              addr,
    input  logic              rd_insvc_sel,
    input  logic [DATA_W-1:0] req_in,
    input  logic [DATA_W-1:0] insvc_in,
    input  logic [DATA_W-1:0] mask_in,
    output logic [DATA_W-1:0] rdata
);
    // Capture the selected register on each read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (rd_en)
            rdata <= addr ? mask_in : (rd_insvc_sel ? insvc_in : req_in);
    end

    // Read data changes only on a read strobe.
    p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

endmodule

// File: rtl/irqc_cmd_port.sv
`timescale 1ns/1ps
// Interrupt controller command port (top).
// Decodes the byte-wide write interface into start words, sequence words,
// read-control words, commands and mask loads, and owns the mask register.
// Assumes at most one of wr_en / rd_en per cycle from the host.
module irqc_cmd_port #(
    parameter int DATA_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      addr,
    input  logic                      wr_en,
    input  logic                      rd_en,
    input  logic [DATA_W-1:0]         wdata,
    input  logic [DATA_W-1:0]         req_in,
    input  logic [DATA_W-1:0]         insvc_in,
    output logic [DATA_W-1:0]         rdata,
    output logic [DATA_W-1:0]         mask_out,
    output logic [DATA_W-1:0]         vec_base,
    output logic [$clog2(DATA_W)-1:0] prio_base,
    output logic [DATA_W-1:0]         insvc_clr,
    output logic                      insvc_clr_all,
    output logic                      init_busy,
    output logic                      single_unit,
    output logic                      nested_special,
    output logic                      auto_eoi,
    output logic                      rot_on_aeoi,
    output logic                      spec_mask
);
    logic start_stb;
    logic rdctl_stb;
    logic cmd_stb;
    logic port1_stb;
    logic mask_stb;
    logic rd_insvc_sel;

    // Classify the current write.
    always_comb begin
        start_stb = wr_en && !addr && wdata[4];
        rdctl_stb = wr_en && !addr && !wdata[4] && wdata[3];
        cmd_stb   = wr_en && !addr && !wdata[4] && !wdata[3];
        port1_stb = wr_en && addr;
        mask_stb  = port1_stb && !init_busy;
    end

    // Mask register: cleared by a start word, loaded when idle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_out <= '0;
        else if (start_stb)
            mask_out <= '0;
        else if (mask_stb)
            mask_out <= wdata;
    end

    // One-cycle request to empty the in-service register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            insvc_clr_all <= 1'b0;
        else
            insvc_clr_all <= start_stb;
    end

    irqc_init_seq #(.DATA_W(DATA_W)) u_init (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_stb      (start_stb),
        .port1_stb      (port1_stb),
        .wdata          (wdata),
        .busy           (init_busy),
        .single_unit    (single_unit),
        .nested_special (nested_special),
        .auto_eoi       (auto_eoi),
        .vec_base       (vec_base)
    );

    irqc_cmd_exec #(.DATA_W(DATA_W)) u_exec (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_stb    (start_stb),
        .rdctl_stb    (rdctl_stb),
        .cmd_stb      (cmd_stb),
        .wdata        (wdata),
        .insvc_in     (insvc_in),
        .prio_base    (prio_base),
        .insvc_clr    (insvc_clr),
        .rd_insvc_sel (rd_insvc_sel),
        .spec_mask    (spec_mask),
        .rot_on_aeoi  (rot_on_aeoi)
    );

    irqc_rd_port #(.DATA_W(DATA_W)) u_rd (
        .clk          (clk),
        .rst_n        (rst_n),
        .rd_en        (rd_en),
        .addr         (addr),
        .rd_insvc_sel (rd_insvc_sel),
        .req_in       (req_in),
        .insvc_in     (insvc_in),
        .mask_in      (mask_out),
        .rdata        (rdata)
    );

    // A start word empties the mask.
    p_start_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_stb |=> (mask_out == '0));

    // The mask cannot change while the sequence consumes address-1 writes.
    p_mask_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (init_busy && !start_stb) |=> $stable(mask_out));

    // The clear-all strobe follows a start word by exactly one cycle.
    p_clr_all_r2: assert property (@(posedge clk) disable iff (!rst_n)
        insvc_clr_all |-> $past(start_stb));

endmodule

// File: tb/tb_irqc_cmd_port.sv
`timescale 1ns/1ps
module tb_irqc_cmd_port;

    typedef enum logic [2:0] {K_MASK, K_VEC, K_BASE, K_CLR, K_CLRALL, K_BUSY, K_FLAGS, K_RDATA} kind_t;
    typedef struct {
        kind_t      kind;
        logic [7:0] val;
        string      tag;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       addr = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] req_in = '0;
    logic [7:0] insvc_in = '0;
    logic [7:0] rdata, mask_out, vec_base, insvc_clr;
    logic [2:0] prio_base;
    logic       insvc_clr_all, init_busy, single_unit, nested_special;
    logic       auto_eoi, rot_on_aeoi, spec_mask;

    int    checks = 0;
    int    failures = 0;
    bit    done = 1'b0;
    item_t sb[$];

    always #10 clk = ~clk;

    irqc_cmd_port dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .req_in(req_in), .insvc_in(insvc_in), .rdata(rdata),
        .mask_out(mask_out), .vec_base(vec_base), .prio_base(prio_base),
        .insvc_clr(insvc_clr), .insvc_clr_all(insvc_clr_all), .init_busy(init_busy),
        .single_unit(single_unit), .nested_special(nested_special), .auto_eoi(auto_eoi),
        .rot_on_aeoi(rot_on_aeoi), .spec_mask(spec_mask)
    );

    // Flags packed as {single, nested, auto_eoi, rotate, special mask}.
    function automatic logic [7:0] observe(kind_t k);
        case (k)
            K_MASK:   return mask_out;
            K_VEC:    return vec_base;
            K_BASE:   return {5'd0, prio_base};
            K_CLR:    return insvc_clr;
            K_CLRALL: return {7'd0, insvc_clr_all};
            K_BUSY:   return {7'd0, init_busy};
            K_FLAGS:  return {3'd0, single_unit, nested_special, auto_eoi, rot_on_aeoi, spec_mask};
            default:  return rdata;
        endcase
    endfunction

    // Monitor: compares every queued expectation on the falling edge.
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            checks++;
            if (observe(it.kind) !== it.val) begin
                failures++;
                $display("FAIL %s kind=%s actual=%02h expected=%02h",
                         it.tag, it.kind.name(), observe(it.kind), it.val);
            end
        end
    end

    task automatic push(kind_t k, logic [7:0] v, string tag);
        item_t it;
        it.kind = k; it.val = v; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic write(logic a, logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic read(logic a);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(posedge clk);
        #1 rd_en = 1'b0;
    endtask

    task automatic push_state(logic [7:0] m, logic [7:0] v, logic [7:0] b,
                              logic bz, logic [7:0] f, string tag);
        push(K_MASK, m, tag);
        push(K_VEC, v, tag);
        push(K_BASE, b, tag);
        push(K_BUSY, {7'd0, bz}, tag);
        push(K_FLAGS, f, tag);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            finish_run();
        end
    end

    // Driver.
    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk); #1;
        // R1: reset state
        push_state(8'h00, 8'h00, 8'h00, 1'b0, 8'h00, "R1");
        push(K_CLR, 8'h00, "R1");
        push(K_CLRALL, 8'h00, "R1");

        // R10: mask load while idle and read-back
        write(1'b1, 8'h5A);
        push(K_MASK, 8'h5A, "R10");
        read(1'b1);
        push(K_RDATA, 8'h5A, "R10");

        // R2: start word, single, fourth wanted, level bit ignored
        write(1'b0, 8'h1B);
        push_state(8'h00, 8'h00, 8'h00, 1'b1, 8'h10, "R2");
        push(K_CLRALL, 8'h01, "R2");
        // R3: vector word low bits dropped; R4: single with fourth word keeps busy
        write(1'b1, 8'h27);
        push(K_VEC, 8'h20, "R3");
        push(K_BUSY, 8'h01, "R4");
        push(K_CLRALL, 8'h00, "R2");
        // R5: fourth word sets nested and auto-EOI, ends sequence
        write(1'b1, 8'h12);
        push_state(8'h00, 8'h20, 8'h00, 1'b0, 8'h1C, "R5");
        write(1'b1, 8'hF0);
        push(K_MASK, 8'hF0, "R10");

        // R4: cascaded, no fourth word: vector then cascade word
        write(1'b0, 8'h10);
        push_state(8'h00, 8'h20, 8'h00, 1'b1, 8'h00, "R2");
        write(1'b1, 8'h08);
        push(K_VEC, 8'h08, "R3");
        push(K_BUSY, 8'h01, "R4");
        write(1'b1, 8'h04);
        push(K_BUSY, 8'h00, "R4");
        push(K_MASK, 8'h00, "R4");

        // R4: single without fourth word ends on the vector word
        write(1'b0, 8'h12);
        write(1'b1, 8'h40);
        push_state(8'h00, 8'h40, 8'h00, 1'b0, 8'h10, "R4");

        // R6: read-control selects in-service / request; special mask
        req_in = 8'h3C; insvc_in = 8'hA5;
        write(1'b0, 8'h0B);
        read(1'b0);
        push(K_RDATA, 8'hA5, "R6");
        write(1'b0, 8'h0A);
        read(1'b0);
        push(K_RDATA, 8'h3C, "R6");
        write(1'b0, 8'h28);
        push(K_FLAGS, 8'h11, "R6");

        // R7: rotate-on-auto-EOI set and cleared
        write(1'b0, 8'h80);
        push(K_FLAGS, 8'h13, "R7");
        write(1'b0, 8'h00);
        push(K_FLAGS, 8'h11, "R7");

        // R9: set priority base to 5+1
        write(1'b0, 8'hC5);
        push(K_BASE, 8'h06, "R9");

        // R8: non-specific clear scanning from base 6
        insvc_in = 8'h44;
        write(1'b0, 8'h20);
        push(K_CLR, 8'h40, "R8");
        push(K_BASE, 8'h06, "R8");
        insvc_in = 8'h05;
        write(1'b0, 8'hA0);
        push(K_CLR, 8'h01, "R8");
        push(K_BASE, 8'h01, "R8");
        insvc_in = 8'h00;
        write(1'b0, 8'h20);
        push(K_CLR, 8'h00, "R8");
        push(K_BASE, 8'h01, "R8");
        write(1'b0, 8'hA0);
        push(K_CLR, 8'h00, "R8");
        push(K_BASE, 8'h01, "R8");

        // R9: specific clear, specific clear with rotation
        write(1'b0, 8'h63);
        push(K_CLR, 8'h08, "R9");
        push(K_BASE, 8'h01, "R9");
        write(1'b0, 8'hE2);
        push(K_CLR, 8'h04, "R9");
        push(K_BASE, 8'h03, "R9");
        // R7: command 2 changes nothing
        write(1'b0, 8'h40);
        push(K_CLR, 8'h00, "R7");
        push_state(8'h00, 8'h40, 8'h03, 1'b0, 8'h11, "R7");

        // R2: restart clears base, mask, flags and read select
        write(1'b1, 8'h81);
        push(K_MASK, 8'h81, "R10");
        write(1'b0, 8'h0B);
        write(1'b0, 8'h13);
        push_state(8'h00, 8'h40, 8'h00, 1'b1, 8'h10, "R2");
        insvc_in = 8'hA5;
        read(1'b0);
        push(K_RDATA, 8'h3C, "R2");

        repeat (3) @(negedge clk);
        done = 1'b1;
        finish_run();
    end

endmodule